// File: doc/BRIEF.md
# Extended-Precision Value Classifier and Compare Encoder

This combinational block works on 80-bit extended-precision operands made of a sign bit, a 15-bit exponent and a 64-bit mantissa whose top bit is an explicit integer bit. It has three jobs. First, it sorts operand A into a value class and encodes that class as four condition bits for an examine operation. Second, it derives the 2-bit tag class that a tag word keeps for each register. Third, it compares A with B as sign and magnitude values, detecting NaNs. It then writes the outcome into the condition bits of a 16-bit status word and into the carry, parity and zero bits of an integer flag word.

The block holds no state. Both words enter on inputs and leave on outputs with only their condition or flag positions rewritten, so the surrounding pipeline keeps ownership of the registers. A quiet-compare input picks which NaNs make the invalid-operand output rise.

Top module: `xp_class_cmp`

## Requirements
- R1: `exam_cc` is {C3,C2,C1,C0} (bit 3 down to bit 0). For every input, C1 (bit 1) equals the sign bit (bit 79) of `a_val`.
- R2: When `a_empty` is high, C3 and C0 are set and C2 is clear, whatever `a_val` holds.
- R3: For a non-empty operand with exponent 0x7FFF, a mantissa of exactly 0x8000000000000000 (infinity) sets C2 and C0 and clears C3. Any other mantissa (NaN) sets C0 only.
- R4: For a non-empty operand with exponent zero, a zero mantissa sets C3 only. A nonzero mantissa (denormal) sets C3 and C2.
- R5: A non-empty operand whose exponent is neither zero nor 0x7FFF sets C2 only.
- R6: `rel` is 0 for A<B, 1 for equal, 2 for A>B and 3 for unordered. Either operand being a NaN gives unordered. +0 and -0 compare equal. Otherwise ordering follows sign and then the magnitude {exponent, mantissa}.
- R7: `cmp_invalid` is high for any NaN operand when `quiet_cmp` is low. When `quiet_cmp` is high, it is high only for a signalling NaN, which has mantissa bit 62 clear.
- R8: `sw_out` equals `sw_in`, except bits 14 (C3), 10 (C2) and 8 (C0). Those bits become 001 for less, 100 for equal, 000 for greater and 111 for unordered.
- R9: `flags_out` equals `flags_in`, except bits 6 (ZF), 2 (PF) and 0 (CF). Those bits become 001 for less, 100 for equal, 000 for greater and 111 for unordered.
- R10: `tag_cls` is 11 when `a_empty` is high. Otherwise it is 01 for exponent and mantissa both zero, and 10 for exponent 0 or 0x7FFF or mantissa bit 63 clear. It is 00 for all other values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_val | input | 80 | Operand A, examined, tagged and compared |
| a_empty | input | 1 | Register holding A is empty |
| b_val | input | 80 | Operand B, the compare reference |
| quiet_cmp | input | 1 | Quiet compare: only signalling NaNs are invalid |
| sw_in | input | 16 | Status word before the compare |
| flags_in | input | FLAG_W | Integer flag word before the compare |
| exam_cc | output | 4 | Examine condition bits {C3,C2,C1,C0} |
| tag_cls | output | 2 | Tag class of A |
| rel | output | 2 | Compare outcome code |
| cmp_invalid | output | 1 | Invalid-operand indication of the compare |
| sw_out | output | 16 | Status word with condition bits rewritten |
| flags_out | output | FLAG_W | Flag word with ZF, PF, CF rewritten |

## Verification
On every input change, the assertions check the following. C1 mirrors the sign. An empty register yields its fixed class and tag. Bits outside the rewritten positions pass through both words untouched. The status word bits agree with the flag word bits, because the two mappers are separate logic. Unordered results raise the invalid flag in the signalling mode. Only the bench scenarios can show that each class lands on the right code and that ordering holds for mixed signs, for negative magnitudes and for signed zeros. They also show that quiet NaNs are tolerated only in the quiet mode.

// File: rtl/xp_pkg.sv
package xp_pkg;
  localparam int EXP_W = 15;
  localparam int MAN_W = 64;
  localparam int VAL_W = 1 + EXP_W + MAN_W;
  localparam logic [EXP_W-1:0] EXP_TOP = '1;
  localparam logic [MAN_W-1:0] MAN_INF = {1'b1, {(MAN_W-1){1'b0}}};
  localparam int INT_BIT = MAN_W - 1;
  localparam int QUIET_BIT = MAN_W - 2;

  // status word condition bit positions
  localparam int SW_C0 = 8;
  localparam int SW_C2 = 10;
  localparam int SW_C3 = 14;
  // integer flag word positions
  localparam int FL_CF = 0;
  localparam int FL_PF = 2;
  localparam int FL_ZF = 6;

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } xval_t;

  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_t;

  function automatic logic f_zero(xval_t v);
    return (v.exp == '0) && (v.man == '0);
  endfunction

  function automatic logic f_inf(xval_t v);
    return (v.exp == EXP_TOP) && (v.man == MAN_INF);
  endfunction

  function automatic logic f_nan(xval_t v);
    return (v.exp == EXP_TOP) && (v.man != MAN_INF);
  endfunction

  function automatic logic f_snan(xval_t v);
    return f_nan(v) && !v.man[QUIET_BIT];
  endfunction

  // {C3,C2,C0} flag triple for a compare outcome
  function automatic logic [2:0] f_rel_bits(rel_t r);
    case (r)
      REL_LT:  return 3'b001;
      REL_EQ:  return 3'b100;
      REL_GT:  return 3'b000;
      default: return 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/xp_classify.sv
module xp_classify
  import xp_pkg::*;
(
  input  xval_t       val,
  input  logic        empty,
  output logic [3:0]  cc,
  output logic [1:0]  tag
);
  logic exp_lo, exp_hi, is_zero, is_inf;

  always_comb begin
    exp_lo  = (val.exp == '0);
    exp_hi  = (val.exp == EXP_TOP);
    is_zero = f_zero(val);
    is_inf  = f_inf(val);
  end

  // cc = {C3,C2,C1,C0}
  always_comb begin
    cc    = 4'b0000;
    cc[1] = val.sgn;
    if (empty) begin
      cc[3] = 1'b1;
      cc[0] = 1'b1;
    end else if (exp_hi) begin
      cc[0] = 1'b1;
      cc[2] = is_inf;
    end else if (exp_lo) begin
      cc[3] = 1'b1;
      cc[2] = !is_zero;
    end else begin
      cc[2] = 1'b1;
    end
  end

  always_comb begin
    if (empty)                                   tag = 2'b11;
    else if (is_zero)                            tag = 2'b01;
    else if (exp_lo || exp_hi || !val.man[INT_BIT]) tag = 2'b10;
    else                                         tag = 2'b00;
  end
endmodule

// File: rtl/xp_compare.sv
module xp_compare
  import xp_pkg::*;
(
  input  xval_t a,
  input  xval_t b,
  input  logic  quiet,
  output rel_t  rel,
  output logic  invalid
);
  logic any_nan, any_snan, both_zero, mag_eq, mag_lt;

  always_comb begin
    any_nan   = f_nan(a) || f_nan(b);
    any_snan  = f_snan(a) || f_snan(b);
    both_zero = f_zero(a) && f_zero(b);
    mag_eq    = {a.exp, a.man} == {b.exp, b.man};
    mag_lt    = {a.exp, a.man} <  {b.exp, b.man};
  end

  always_comb begin
    if (any_nan)             rel = REL_UN;
    else if (both_zero)      rel = REL_EQ;
    else if (a.sgn != b.sgn) rel = a.sgn ? REL_LT : REL_GT;
    else if (mag_eq)         rel = REL_EQ;
    else if (mag_lt ^ a.sgn) rel = REL_LT;
    else                     rel = REL_GT;
  end

  assign invalid = quiet ? any_snan : any_nan;
endmodule

// File: rtl/xp_ccmap.sv
module xp_ccmap
  import xp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int POS_HI = 14,
  parameter int POS_MD = 10,
  parameter int POS_LO = 8
) (
  input  rel_t              rel,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_out
);
  localparam logic [WORD_W-1:0] MASK =
    (WORD_W'(1) << POS_HI) | (WORD_W'(1) << POS_MD) | (WORD_W'(1) << POS_LO);

  logic [2:0] bits;

  always_comb begin
    bits             = f_rel_bits(rel);
    word_out         = word_in & ~MASK;
    word_out[POS_HI] = bits[2];
    word_out[POS_MD] = bits[1];
    word_out[POS_LO] = bits[0];
  end
endmodule

// File: rtl/xp_class_cmp.sv
module xp_class_cmp
  import xp_pkg::*;
#(
  parameter int FLAG_W = 32
) (
  input  logic [VAL_W-1:0]  a_val,
  input  logic              a_empty,
  input  logic [VAL_W-1:0]  b_val,
  input  logic              quiet_cmp,
  input  logic [15:0]       sw_in,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [3:0]        exam_cc,
  output logic [1:0]        tag_cls,
  output logic [1:0]        rel,
  output logic              cmp_invalid,
  output logic [15:0]       sw_out,
  output logic [FLAG_W-1:0] flags_out
);
  xval_t a_s, b_s;
  rel_t  rel_e;

  assign a_s = xval_t'(a_val);
  assign b_s = xval_t'(b_val);

  xp_classify u_cls (
    .val   (a_s),
    .empty (a_empty),
    .cc    (exam_cc),
    .tag   (tag_cls)
  );

  xp_compare u_cmp (
    .a       (a_s),
    .b       (b_s),
    .quiet   (quiet_cmp),
    .rel     (rel_e),
    .invalid (cmp_invalid)
  );

  assign rel = rel_e;

  xp_ccmap #(.WORD_W(16), .POS_HI(SW_C3), .POS_MD(SW_C2), .POS_LO(SW_C0)) u_swmap (
    .rel      (rel_e),
    .word_in  (sw_in),
    .word_out (sw_out)
  );

  xp_ccmap #(.WORD_W(FLAG_W), .POS_HI(FL_ZF), .POS_MD(FL_PF), .POS_LO(FL_CF)) u_flmap (
    .rel      (rel_e),
    .word_in  (flags_in),
    .word_out (flags_out)
  );
endmodule

// File: rtl/xp_class_cmp_chk.sv
module xp_class_cmp_chk
  import xp_pkg::*;
#(
  parameter int FLAG_W = 32
) (
  input logic [VAL_W-1:0]  a_val,
  input logic              a_empty,
  input logic              quiet_cmp,
  input logic [15:0]       sw_in,
  input logic [FLAG_W-1:0] flags_in,
  input logic [3:0]        exam_cc,
  input logic [1:0]        tag_cls,
  input logic [1:0]        rel,
  input logic              cmp_invalid,
  input logic [15:0]       sw_out,
  input logic [FLAG_W-1:0] flags_out
);
  localparam logic [15:0] SW_M = 16'h4500;
  localparam logic [FLAG_W-1:0] FL_M = FLAG_W'(32'h45);

  always_comb begin
    p_c1_sign_r1: assert (exam_cc[1] == a_val[VAL_W-1]);
    if (a_empty) begin
      p_empty_cc_r2: assert (exam_cc[3] && !exam_cc[2] && exam_cc[0]);
    end
    p_empty_tag_r10: assert ((tag_cls == 2'b11) == a_empty);
    if (rel == 2'd3 && !quiet_cmp) begin
      p_unord_invalid_r7: assert (cmp_invalid);
    end
    p_sw_keep_r8: assert ((sw_out & ~SW_M) == (sw_in & ~SW_M));
    p_fl_keep_r9: assert ((flags_out & ~FL_M) == (flags_in & ~FL_M));
    p_sw_fl_agree_r9: assert (sw_out[14] == flags_out[6] && sw_out[10] == flags_out[2]
                              && sw_out[8] == flags_out[0]);
  end
endmodule

bind xp_class_cmp xp_class_cmp_chk #(.FLAG_W(FLAG_W)) u_chk (
  .a_val       (a_val),
  .a_empty     (a_empty),
  .quiet_cmp   (quiet_cmp),
  .sw_in       (sw_in),
  .flags_in    (flags_in),
  .exam_cc     (exam_cc),
  .tag_cls     (tag_cls),
  .rel         (rel),
  .cmp_invalid (cmp_invalid),
  .sw_out      (sw_out),
  .flags_out   (flags_out)
);

// File: tb/xp_class_cmp_test.sv
module xp_class_cmp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [79:0] a_val = '0, b_val = '0;
  logic        a_empty = 1'b0, quiet_cmp = 1'b0;
  logic [15:0] sw_in = '0;
  logic [31:0] flags_in = '0;
  logic [3:0]  exam_cc;
  logic [1:0]  tag_cls, rel;
  logic        cmp_invalid;
  logic [15:0] sw_out;
  logic [31:0] flags_out;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xp_class_cmp #(.FLAG_W(32)) uut (.*);

  localparam logic [79:0] P1   = {1'b0, 15'h3fff, 64'h8000_0000_0000_0000};
  localparam logic [79:0] P2   = {1'b0, 15'h4000, 64'h8000_0000_0000_0000};
  localparam logic [79:0] N1   = {1'b1, 15'h3fff, 64'h8000_0000_0000_0000};
  localparam logic [79:0] N2   = {1'b1, 15'h4000, 64'h8000_0000_0000_0000};
  localparam logic [79:0] PZ   = '0;
  localparam logic [79:0] NZ   = {1'b1, 79'h0};
  localparam logic [79:0] PINF = {1'b0, 15'h7fff, 64'h8000_0000_0000_0000};
  localparam logic [79:0] NINF = {1'b1, 15'h7fff, 64'h8000_0000_0000_0000};
  localparam logic [79:0] QNAN = {1'b0, 15'h7fff, 64'hC000_0000_0000_0000};
  localparam logic [79:0] SNAN = {1'b1, 15'h7fff, 64'hA000_0000_0000_0001};
  localparam logic [79:0] DEN  = {1'b1, 15'h0000, 64'h0000_0000_0000_0010};
  localparam logic [79:0] UNN  = {1'b0, 15'h1234, 64'h4000_0000_0000_0000};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [79:0] a, logic e, logic [79:0] b, logic q,
                       logic [15:0] sw, logic [31:0] fl);
    @(negedge clk);
    a_val = a; a_empty = e; b_val = b; quiet_cmp = q; sw_in = sw; flags_in = fl;
    #1;
  endtask

  // ordering key: signed magnitude mapped onto a two's complement integer
  function automatic logic signed [80:0] key(logic [79:0] v);
    logic signed [80:0] m;
    m = $signed({2'b00, v[78:0]});
    return v[79] ? -m : m;
  endfunction

  function automatic logic is_nan_ref(logic [79:0] v);
    return v[78:64] == 15'h7fff && v[63:0] != 64'h8000_0000_0000_0000;
  endfunction

  function automatic logic [1:0] rel_ref(logic [79:0] a, logic [79:0] b);
    if (is_nan_ref(a) || is_nan_ref(b)) return 2'd3;
    if (key(a) < key(b)) return 2'd0;
    if (key(a) > key(b)) return 2'd2;
    return 2'd1;
  endfunction

  task automatic t_reset;
    drive(PZ, 1'b0, PZ, 1'b0, 16'h0000, 32'h0);
    chk("R4 reset zero class", 32'(exam_cc), 32'h8);
    chk("R10 reset tag", 32'(tag_cls), 32'h1);
    chk("R6 reset equal", 32'(rel), 32'h1);
    chk("R8 reset sw", 32'(sw_out), 32'h4000);
  endtask

  task automatic t_examine;
    drive(N1, 1'b1, PZ, 1'b0, 16'h0, 32'h0);
    chk("R2 empty neg", 32'(exam_cc), 32'b1011);
    drive(PINF, 1'b1, PZ, 1'b0, 16'h0, 32'h0);
    chk("R2 empty ignores contents", 32'(exam_cc), 32'b1001);
    drive(NINF, 1'b0, PZ, 1'b0, 16'h0, 32'h0);
    chk("R3 -inf", 32'(exam_cc), 32'b0111);
    drive(QNAN, 1'b0, PZ, 1'b0, 16'h0, 32'h0);
    chk("R3 nan", 32'(exam_cc), 32'b0001);
    drive(NZ, 1'b0, PZ, 1'b0, 16'h0, 32'h0);
    chk("R4 -zero", 32'(exam_cc), 32'b1010);
    drive(DEN, 1'b0, PZ, 1'b0, 16'h0, 32'h0);
    chk("R4 denormal", 32'(exam_cc), 32'b1110);
    drive(P2, 1'b0, PZ, 1'b0, 16'h0, 32'h0);
    chk("R5 normal", 32'(exam_cc), 32'b0100);
    chk("R1 sign clear", 32'(exam_cc[1]), 32'h0);
  endtask

  task automatic t_tag;
    drive(P1, 1'b0, PZ, 1'b0, 16'h0, 32'h0);
    chk("R10 valid", 32'(tag_cls), 32'h0);
    drive(UNN, 1'b0, PZ, 1'b0, 16'h0, 32'h0);
    chk("R10 integer bit clear", 32'(tag_cls), 32'h2);
    drive(DEN, 1'b0, PZ, 1'b0, 16'h0, 32'h0);
    chk("R10 denormal special", 32'(tag_cls), 32'h2);
    drive(PINF, 1'b0, PZ, 1'b0, 16'h0, 32'h0);
    chk("R10 inf special", 32'(tag_cls), 32'h2);
    drive(P1, 1'b1, PZ, 1'b0, 16'h0, 32'h0);
    chk("R10 empty", 32'(tag_cls), 32'h3);
  endtask

  task automatic cmp_case(string req, logic [79:0] a, logic [79:0] b, logic q);
    logic [1:0] r;
    logic [2:0] bits;
    r = rel_ref(a, b);
    case (r)
      2'd0: bits = 3'b001;
      2'd1: bits = 3'b100;
      2'd2: bits = 3'b000;
      default: bits = 3'b111;
    endcase
    drive(a, 1'b0, b, q, 16'hFFFF, 32'hA5A5_5A5A);
    chk({req, " R6 rel"}, 32'(rel), 32'(r));
    chk({req, " R8 sw"}, 32'(sw_out),
        32'((16'hFFFF & ~16'h4500) | {1'b0, bits[2], 3'b0, bits[1], 1'b0, bits[0], 8'h0}));
    chk({req, " R9 flags"}, flags_out,
        (32'hA5A5_5A5A & ~32'h45) | {25'h0, bits[2], 3'b0, bits[1], 1'b0, bits[0]});
  endtask

  task automatic t_compare;
    cmp_case("1<2", P1, P2, 1'b0);
    cmp_case("2>1", P2, P1, 1'b0);
    cmp_case("-1<1", N1, P1, 1'b0);
    cmp_case("-2<-1", N2, N1, 1'b0);
    cmp_case("+0=-0", PZ, NZ, 1'b0);
    cmp_case("1=1", P1, P1, 1'b0);
    cmp_case("-inf<den", NINF, DEN, 1'b0);
    cmp_case("nan", QNAN, P1, 1'b1);
    chk("R6 +0 vs -0 equal", 32'(rel_ref(PZ, NZ)), 32'h1);
  endtask

  task automatic t_invalid;
    drive(QNAN, 1'b0, P1, 1'b1, 16'h0, 32'h0);
    chk("R7 quiet qnan", 32'(cmp_invalid), 32'h0);
    drive(P1, 1'b0, QNAN, 1'b0, 16'h0, 32'h0);
    chk("R7 signalling qnan", 32'(cmp_invalid), 32'h1);
    drive(P1, 1'b0, SNAN, 1'b1, 16'h0, 32'h0);
    chk("R7 quiet snan", 32'(cmp_invalid), 32'h1);
    drive(P1, 1'b0, P2, 1'b0, 16'h0, 32'h0);
    chk("R7 ordered", 32'(cmp_invalid), 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset;
    t_examine;
    t_tag;
    t_compare;
    t_invalid;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule